// File: doc/BRIEF.md
# Interrupt Status Event Queue

This block collects events from five sources of a network controller and hands them to software one at a time through a single 16-bit read port. Three sources carry flag words: receive, transmit and buffer. The other two are counters, one for missed frames and one for collisions. Each word that software reads names its source in the low bits and carries that source's latched content in the upper bits. Software reads the port again and again until it returns zero. Each read that returns an entry acknowledges that entry.

Flag events are OR-ed into a latched word per source. Counter sources count increment pulses. A counter becomes visible only once it has passed half of its range. The source with the highest priority is presented first, and the word is valid in the same cycle as the state it reflects. A read strobe in a cycle consumes the presented entry at the next clock edge. One interrupt line is high whenever an enable input is set and any entry is pending.

Top module: `evt_status_queue`

## Requirements
- R1: A non-empty word carries the source tag in bits 5:0 and the source content in bits 15:6. The tags are 0x04 for receive, 0x08 for transmit, 0x0C for buffer, 0x10 for the missed-frame counter and 0x12 for the collision counter. For a flag source, content bit k is the latched flag input bit k. For example, word bit 8 (good frame) is receive flag bit 2.
- R2: When nothing is pending, `rd_data_o` reads 0x0000. This is the state after reset.
- R3: An event pulse ORs its flag input into that source's latched content. The flags accumulate across pulses until the entry is read. A pulse whose flags are all zero makes nothing pending.
- R4: When several entries are pending, the presented entry follows a fixed priority: receive, then transmit, then buffer, then missed-frame, then collision.
- R5: A read strobe clears only the source that is currently presented. Every other pending source keeps its content.
- R6: If an event for the presented source arrives in the same cycle as the read that clears it, that event is kept and presented on a later read.
- R7: Each counter adds one per increment pulse and saturates at 1023. Its entry is pending while its count is at least 512 (bit 9 set), and the content is the count.
- R8: Reading a counter entry resets that counter to 0. It resets to 1 instead if an increment arrives in the same cycle.
- R9: `irq_o` is high exactly when `irq_en_i` is 1 and `rd_data_o` is non-zero.
- R10: A read strobe while the queue is empty changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rx_evt_i | input | 1 | Receive event pulse |
| rx_flags_i | input | 10 | Receive event flags (word bits 15:6) |
| tx_evt_i | input | 1 | Transmit event pulse |
| tx_flags_i | input | 10 | Transmit event flags |
| buf_evt_i | input | 1 | Buffer event pulse |
| buf_flags_i | input | 10 | Buffer event flags |
| miss_inc_i | input | 1 | Missed-frame counter increment |
| col_inc_i | input | 1 | Collision counter increment |
| rd_i | input | 1 | Read strobe, consumes the presented entry |
| irq_en_i | input | 1 | Interrupt enable (bit 15 of the bus control word) |
| rd_data_o | output | 16 | Presented tagged event word, zero when empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The output word is combinational from the latched state. A wrong latch, counter or grant therefore appears on `rd_data_o` and `irq_o` in the very cycle after the faulty edge. It shows up as a wrong tag, a lost or duplicated flag, or a counter entry that appears too early or too late. A reference model in the bench steps with every clock and is compared on every cycle. Directed sequences cover same-cycle retention, saturation and the half-range threshold, which random traffic seldom reaches.

// File: rtl/evq_pkg.sv
// Package: shared widths, source indices and tag values for the event queue.
// Assumes the word is 16 bits split into a 6-bit tag and a 10-bit content field.
package evq_pkg;
    localparam int TAG_W     = 6;
    localparam int CONTENT_W = 10;
    localparam int WORD_W    = TAG_W + CONTENT_W;
    localparam int NSRC      = 5;
    localparam int NFLAG     = 3;

    // Source order is the presentation priority (index 0 wins).
    typedef enum logic [2:0] {
        SRC_RX   = 3'd0,
        SRC_TX   = 3'd1,
        SRC_BUF  = 3'd2,
        SRC_MISS = 3'd3,
        SRC_COL  = 3'd4
    } src_e;

    // Tag placed in bits 5:0 for each source.
    function automatic logic [TAG_W-1:0] src_tag(input int idx);
        case (idx)
            0:       return 6'h04;
            1:       return 6'h08;
            2:       return 6'h0C;
            3:       return 6'h10;
            default: return 6'h12;
        endcase
    endfunction
endpackage

// File: rtl/evq_flag_latch.sv
// Module: holds the accumulated flags of one event source.
// Assumes clr_i is asserted only while this source is the presented entry;
// flags arriving with clr_i are retained.
module evq_flag_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic         evt_i,
    input  logic [W-1:0] flags_i,
    input  logic         clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;

    // Accumulate new flags, dropping old ones when acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= (clr_i ? '0 : pend_q) | (evt_i ? flags_i : '0);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/evq_event_counter.sv
// Module: saturating event counter that reports pending from half range.
// Assumes one increment per cycle at most; clear with increment yields one.
module evq_event_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] count_o,
    output logic         half_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    // Count increments, saturate at the top, restart on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (clr_i)         cnt_q <= inc_i ? ONE : '0;
        else if (inc_i && cnt_q != MAXV) cnt_q <= cnt_q + ONE;
    end

    assign count_o = cnt_q;
    assign half_o  = cnt_q[W-1];
endmodule

// File: rtl/evq_arbiter.sv
// Module: fixed-priority pick among pending sources and word assembly.
// Assumes index 0 has highest priority; output is zero when no request.
module evq_arbiter #(
    parameter int N         = 5,
    parameter int CONTENT_W = 10,
    parameter int TAG_W     = 6
) (
    input  logic [N-1:0]                req_i,
    input  logic [N-1:0][CONTENT_W-1:0] content_i,
    input  logic [N-1:0][TAG_W-1:0]     tag_i,
    output logic [N-1:0]                grant_o,
    output logic [CONTENT_W+TAG_W-1:0]  word_o
);
    // Walk from lowest priority upward so the highest request wins last.
    always_comb begin
        grant_o = '0;
        word_o  = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                word_o     = {content_i[i], tag_i[i]};
            end
        end
    end
endmodule

// File: rtl/evt_status_queue.sv
// Module: merges three flag sources and two counters into one tagged,
// read-to-clear status port with an enable-gated interrupt line.
// Assumes rd_i is a single-cycle strobe per consumed word.
module evt_status_queue
    import evq_pkg::*;
#(
    parameter int CW = evq_pkg::CONTENT_W,
    parameter int TW = evq_pkg::TAG_W
) (
    input  logic           clk,
    input  logic           rst_ni,
    input  logic           rx_evt_i,
    input  logic [CW-1:0]  rx_flags_i,
    input  logic           tx_evt_i,
    input  logic [CW-1:0]  tx_flags_i,
    input  logic           buf_evt_i,
    input  logic [CW-1:0]  buf_flags_i,
    input  logic           miss_inc_i,
    input  logic           col_inc_i,
    input  logic           rd_i,
    input  logic           irq_en_i,
    output logic [CW+TW-1:0] rd_data_o,
    output logic           irq_o
);
    localparam int NS = evq_pkg::NSRC;
    localparam int NF = evq_pkg::NFLAG;
    localparam int NC = NS - NF;

    logic [NF-1:0]          flag_evt;
    logic [NF-1:0][CW-1:0]  flag_in;
    logic [NC-1:0]          cnt_inc;
    logic [NS-1:0]          req;
    logic [NS-1:0][CW-1:0]  content;
    logic [NS-1:0][TW-1:0]  tags;
    logic [NS-1:0]          grant;
    logic [NS-1:0]          clr;
    logic [CW+TW-1:0]       word;

    // Gather per-source inputs into arrays in priority order.
    always_comb begin
        flag_evt = {buf_evt_i, tx_evt_i, rx_evt_i};
        flag_in  = {buf_flags_i, tx_flags_i, rx_flags_i};
        cnt_inc  = {col_inc_i, miss_inc_i};
    end

    // Acknowledge only the presented source on a read.
    assign clr = rd_i ? grant : '0;

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_flag
            logic [CW-1:0] pend;
            evq_flag_latch #(.W(CW)) u_latch (
                .clk    (clk),
                .rst_ni (rst_ni),
                .evt_i  (flag_evt[g]),
                .flags_i(flag_in[g]),
                .clr_i  (clr[g]),
                .pend_o (pend)
            );
            assign content[g] = pend;
            assign req[g]     = |pend;
            assign tags[g]    = src_tag(g);
        end
        for (g = 0; g < NC; g++) begin : g_cnt
            logic [CW-1:0] cnt;
            logic          half;
            evq_event_counter #(.W(CW)) u_cnt (
                .clk    (clk),
                .rst_ni (rst_ni),
                .inc_i  (cnt_inc[g]),
                .clr_i  (clr[NF+g]),
                .count_o(cnt),
                .half_o (half)
            );
            assign content[NF+g] = cnt;
            assign req[NF+g]     = half;
            assign tags[NF+g]    = src_tag(NF+g);
        end
    endgenerate

    evq_arbiter #(.N(NS), .CONTENT_W(CW), .TAG_W(TW)) u_arb (
        .req_i    (req),
        .content_i(content),
        .tag_i    (tags),
        .grant_o  (grant),
        .word_o   (word)
    );

    assign rd_data_o = word;
    assign irq_o     = irq_en_i & (|req);
endmodule

// File: rtl/evq_checker.sv
// Module: temporal checks on the event queue ports and grant vector.
// Assumes the default 10-bit content and 6-bit tag split.
module evq_checker (
    input logic        clk,
    input logic        rst_ni,
    input logic        rx_evt_i,
    input logic [9:0]  rx_flags_i,
    input logic        rd_i,
    input logic        irq_en_i,
    input logic [15:0] rd_data_o,
    input logic        irq_o,
    input logic [4:0]  grant
);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        irq_o == (irq_en_i && rd_data_o != 16'h0));

    // R1
    tag_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        rd_data_o != 16'h0 |-> (rd_data_o[5:0] == 6'h04 || rd_data_o[5:0] == 6'h08 ||
                                rd_data_o[5:0] == 6'h0C || rd_data_o[5:0] == 6'h10 ||
                                rd_data_o[5:0] == 6'h12));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $onehot0(grant) && ((grant == 5'b0) == (rd_data_o == 16'h0)));

    // R5
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_i && rd_data_o[5:0] == 6'h04 && !rx_evt_i) |=> rd_data_o[5:0] != 6'h04);

    // R6
    rx_retain_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_i && rd_data_o[5:0] == 6'h04 && rx_evt_i && rx_flags_i != 10'h0)
        |=> rd_data_o == {$past(rx_flags_i), 6'h04});

    // R8
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_i && rd_data_o[5:0] == 6'h10) |=> rd_data_o[5:0] != 6'h10);
endmodule

bind evt_status_queue evq_checker u_chk (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rx_evt_i  (rx_evt_i),
    .rx_flags_i(rx_flags_i),
    .rd_i      (rd_i),
    .irq_en_i  (irq_en_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .grant     (grant)
);

// File: tb/evt_status_queue_tb.sv
module evt_status_queue_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        rx_evt_i = 0, tx_evt_i = 0, buf_evt_i = 0;
    logic [9:0]  rx_flags_i = '0, tx_flags_i = '0, buf_flags_i = '0;
    logic        miss_inc_i = 0, col_inc_i = 0, rd_i = 0, irq_en_i = 0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0] m_pend [3];
    logic [9:0] m_cnt  [2];

    always #2.5 clk = ~clk;

    evt_status_queue u_dut (
        .clk(clk), .rst_ni(rst_ni),
        .rx_evt_i(rx_evt_i), .rx_flags_i(rx_flags_i),
        .tx_evt_i(tx_evt_i), .tx_flags_i(tx_flags_i),
        .buf_evt_i(buf_evt_i), .buf_flags_i(buf_flags_i),
        .miss_inc_i(miss_inc_i), .col_inc_i(col_inc_i),
        .rd_i(rd_i), .irq_en_i(irq_en_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // Expected presented word from the requirement text (R1, R4, R7).
    function automatic logic [15:0] exp_word();
        if (m_pend[0] != 0) return {m_pend[0], 6'h04};
        if (m_pend[1] != 0) return {m_pend[1], 6'h08};
        if (m_pend[2] != 0) return {m_pend[2], 6'h0C};
        if (m_cnt[0][9])    return {m_cnt[0], 6'h10};
        if (m_cnt[1][9])    return {m_cnt[1], 6'h12};
        return 16'h0000;
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string rq);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Advance the reference model by one clock edge (R3, R5, R6, R8, R10).
    task automatic model_edge();
        logic [15:0] w;
        logic [4:0]  g;
        w = exp_word();
        g = '0;
        if (rd_i && w != 0)
            case (w[5:0])
                6'h04: g[0] = 1; 6'h08: g[1] = 1; 6'h0C: g[2] = 1;
                6'h10: g[3] = 1; default: g[4] = 1;
            endcase
        m_pend[0] = (g[0] ? 10'h0 : m_pend[0]) | (rx_evt_i  ? rx_flags_i  : 10'h0);
        m_pend[1] = (g[1] ? 10'h0 : m_pend[1]) | (tx_evt_i  ? tx_flags_i  : 10'h0);
        m_pend[2] = (g[2] ? 10'h0 : m_pend[2]) | (buf_evt_i ? buf_flags_i : 10'h0);
        if (g[3]) m_cnt[0] = miss_inc_i ? 10'd1 : 10'd0;
        else if (miss_inc_i && m_cnt[0] != 10'h3FF) m_cnt[0] = m_cnt[0] + 1;
        if (g[4]) m_cnt[1] = col_inc_i ? 10'd1 : 10'd0;
        else if (col_inc_i && m_cnt[1] != 10'h3FF) m_cnt[1] = m_cnt[1] + 1;
    endtask

    // Check outputs for current inputs, then clock once; caller is at negedge.
    task automatic step(input string rq);
        logic [15:0] w;
        #1;
        w = exp_word();
        chk(rd_data_o, w, rq);
        chk({15'h0, irq_o}, {15'h0, irq_en_i && w != 0}, "R9");
        model_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        rx_evt_i = 0; tx_evt_i = 0; buf_evt_i = 0;
        miss_inc_i = 0; col_inc_i = 0; rd_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int i = 0; i < 3; i++) m_pend[i] = '0;
        for (int i = 0; i < 2; i++) m_cnt[i] = '0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        irq_en_i = 1'b1;
        // R2: empty after reset
        step("R2");
        // R10: read while empty
        rd_i = 1; step("R10"); idle(); step("R10");
        // R3: accumulate receive flags (good frame = flag bit 2, CRC = bit 6)
        rx_evt_i = 1; rx_flags_i = 10'h004; step("R3");
        rx_flags_i = 10'h040; step("R3"); idle();
        chk(rd_data_o, {10'h044, 6'h04}, "R3");
        // R4: all flag sources pending, receive first
        tx_evt_i = 1; tx_flags_i = 10'h00A; buf_evt_i = 1; buf_flags_i = 10'h101;
        step("R4"); idle();
        // R5: read receive, transmit next with buffer intact
        rd_i = 1; step("R5"); idle();
        chk(rd_data_o, {10'h00A, 6'h08}, "R5");
        // R6: read transmit while a new transmit event arrives
        rd_i = 1; tx_evt_i = 1; tx_flags_i = 10'h200; step("R6"); idle();
        chk(rd_data_o, {10'h200, 6'h08}, "R6");
        rd_i = 1; step("R5"); step("R5"); idle(); step("R2");
        // R7: missed counter appears at 512 only
        miss_inc_i = 1;
        repeat (511) step("R7");
        idle(); chk(rd_data_o, 16'h0, "R7");
        miss_inc_i = 1; step("R7"); idle();
        chk(rd_data_o, {10'd512, 6'h10}, "R7");
        // R7: collision saturates at 1023, under missed in priority
        col_inc_i = 1; repeat (1100) step("R7"); idle();
        // R8: read missed with same-cycle increment, then collision
        rd_i = 1; miss_inc_i = 1; step("R8"); idle();
        chk(rd_data_o, {10'h3FF, 6'h12}, "R8");
        rd_i = 1; step("R8"); idle(); step("R8");
        // R9: disable masks interrupt
        irq_en_i = 0; rx_evt_i = 1; rx_flags_i = 10'h080; step("R9"); idle();
        step("R9"); irq_en_i = 1; step("R9");
        // Random mix
        for (int i = 0; i < 6000; i++) begin
            rx_evt_i   = ($urandom % 6) == 0;
            tx_evt_i   = ($urandom % 7) == 0;
            buf_evt_i  = ($urandom % 9) == 0;
            rx_flags_i = 10'($urandom);
            tx_flags_i = 10'($urandom);
            buf_flags_i = 10'($urandom);
            miss_inc_i = ($urandom % 2) == 0;
            col_inc_i  = ($urandom % 3) == 0;
            rd_i       = ($urandom % 3) == 0;
            irq_en_i   = ($urandom % 8) != 0;
            step("R1");
        end
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule